// File: doc/BRIEF.md
# Debug Access Level Gate

This block stands between an external debug port and a bank of on-chip assets and decides, request by request, whether the debugger may touch a given asset. Each asset has a fixed minimum access level taken from a parameter. A request succeeds only when the debug port is open and the currently authorized level is at or above that asset's level.

The authorized level comes from three things. The first is a shield bit that closes the debug port. It comes out of reset closed, and only a trusted on-chip agent may change it. The second is a pass/fail strobe from an external authentication unit. The third is the boot stage. The highest (full) level can only be obtained while boot is still at stage 0, so nothing left over from a previous session is reachable once boot has moved on. A failed authentication drops the level to public and locks out further attempts for a fixed number of cycles.

The gate answers every request one cycle after it is made, with a grant or deny flag. On a denied read it returns zero data. The asset strobe it forwards is raised only for requests that will be granted.

Top module: `dbg_level_gate`

## Requirements
- R1: The shield bit uses 0 for debug port open and 1 for debug port closed. While it is 1, every request is denied.
- R2: The shield resets to 1 and the gate counts as unconfigured until the trusted agent first writes the shield. Until that write, every request is denied, whatever the shield value.
- R3: Only a trusted-agent write changes the shield. A debug-side shield write leaves the shield unchanged and raises `shield_viol_o` for exactly the next cycle.
- R4: Levels are 2-bit codes: 0 none, 1 public, 2 authenticated, 3 full. The stored authorized level, reported on `auth_level_o`, resets to 1.
- R5: Asset i has the level held in bits [2i+1:2i] of `ASSET_LEVELS`. With the default table this is i mod 4. A request is granted only if the port is open, the gate is configured, i < `NUM_ASSETS`, and the asset level is ≤ the authorized level. Identifiers at or above `NUM_ASSETS` are always denied.
- R6: An accepted pass strobe sets the level to 3 if the boot stage (after this cycle's update) is 0, and to 2 otherwise.
- R7: The stored boot stage becomes the larger of itself and `boot_stage_i`, so it never decreases before reset. Once it is nonzero, a level of 3 is demoted to 2 and level 3 can no longer be reached.
- R8: An accepted fail strobe sets the level to 1 and starts a lockout. During the next `LOCKOUT_CYCLES` cycles, `lockout_o` is 1 and pass and fail strobes are both ignored.
- R9: One cycle after each request, `rsp_valid_o` is 1 and `rsp_grant_o` gives the decision. A granted read returns the `asset_rdata_i` value sampled in the request cycle. A denied request, or any write, returns zero data.
- R10: `asset_en_o` and `asset_we_o` are raised in the request cycle only for requests that will be granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_stage_i | input | 2 | Current boot stage from the boot controller |
| auth_valid_i | input | 1 | Authentication result strobe |
| auth_pass_i | input | 1 | Authentication result: 1 pass, 0 fail |
| trusted_wr_i | input | 1 | Shield write from the trusted on-chip agent |
| trusted_shield_i | input | 1 | Shield value written by the trusted agent |
| dbg_shield_wr_i | input | 1 | Shield write attempt from the debug port |
| req_valid_i | input | 1 | Debug asset request |
| req_write_i | input | 1 | Request is a write |
| req_id_i | input | ID_W | Asset identifier |
| req_wdata_i | input | DATA_W | Write data |
| asset_rdata_i | input | DATA_W | Read data from the selected asset |
| asset_en_o | output | 1 | Asset access strobe (granted requests only) |
| asset_we_o | output | 1 | Asset write strobe (granted writes only) |
| asset_id_o | output | ID_W | Asset identifier to the asset bank |
| asset_wdata_o | output | DATA_W | Write data to the asset bank |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_grant_o | output | 1 | Response: 1 granted, 0 denied |
| rsp_rdata_o | output | DATA_W | Read data, zero when denied |
| auth_level_o | output | 2 | Stored authorized level |
| lockout_o | output | 1 | Authentication lockout active |
| shield_o | output | 1 | Shield bit (1 closes the debug port) |
| shield_viol_o | output | 1 | One-cycle flag for a debug-side shield write |

## Verification
The access decision is exercised by sweeping all sixteen identifiers, as reads and as writes, in several gate states:
- unconfigured;
- configured but closed;
- open at public level;
- open at full level during stage 0;
- open after boot has advanced.

Each sweep separates one threshold of the level comparison and shows the out-of-range identifiers staying denied. Authentication is tried with a pass strobe on every cycle of a lockout, which pins down the exact cycle it ends. It is also tried with pass strobes before and after a boot-stage change, and with a boot stage that tries to move backward. Shield writes are tried from the debug side alone and in the same cycle as a trusted write, to tell apart the ignored path from the effective one.

// File: rtl/dlg_pkg.sv
package dlg_pkg;
    typedef enum logic [1:0] {
        LVL_NONE   = 2'd0,
        LVL_PUBLIC = 2'd1,
        LVL_AUTH   = 2'd2,
        LVL_FULL   = 2'd3
    } dbg_level_e;
endpackage

// File: rtl/dlg_auth_tracker.sv
module dlg_auth_tracker
    import dlg_pkg::*;
#(
    parameter int LOCKOUT_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] boot_stage_i,
    input  logic       auth_valid_i,
    input  logic       auth_pass_i,
    output logic [1:0] level_o,
    output logic       lockout_o
);
    localparam int CNT_W = $clog2(LOCKOUT_CYCLES + 1);

    typedef struct packed {
        logic [1:0]       stage;
        dbg_level_e       level;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic accept;

    always_comb begin
        trk_d  = trk_q;
        accept = auth_valid_i && (trk_q.cnt == '0);
        // boot stage only ratchets forward
        if (boot_stage_i > trk_q.stage) begin
            trk_d.stage = boot_stage_i;
        end
        if (accept) begin
            if (auth_pass_i) begin
                trk_d.level = (trk_d.stage == 2'd0) ? LVL_FULL : LVL_AUTH;
            end else begin
                trk_d.level = LVL_PUBLIC;
                trk_d.cnt   = CNT_W'(LOCKOUT_CYCLES);
            end
        end else if (trk_q.cnt != '0) begin
            trk_d.cnt = trk_q.cnt - 1'b1;
        end
        // full access never survives past the first boot stage
        if ((trk_d.stage != 2'd0) && (trk_d.level == LVL_FULL)) begin
            trk_d.level = LVL_AUTH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.stage <= 2'd0;
            trk_q.level <= LVL_PUBLIC;
            trk_q.cnt   <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign level_o   = trk_q.level;
    assign lockout_o = (trk_q.cnt != '0);

    // R7: stored boot stage never decreases
    a_r7_stage_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.stage >= $past(trk_q.stage));
    // R7: level 3 only while stage is 0
    a_r7_no_full_late: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.stage != 2'd0) |-> (trk_q.level != LVL_FULL));
    // R8: strobes during lockout leave the level untouched
    a_r8_lockout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout_o && auth_valid_i) |=> (trk_q.level == $past(trk_q.level)));
    // R8: accepted fail gives public level and an active lockout
    a_r8_fail_public: assert property (@(posedge clk) disable iff (!rst_n)
        (!lockout_o && auth_valid_i && !auth_pass_i) |=> (level_o == LVL_PUBLIC && lockout_o));
endmodule

// File: rtl/dlg_shield_ctrl.sv
module dlg_shield_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic trusted_wr_i,
    input  logic trusted_shield_i,
    input  logic dbg_wr_i,
    output logic shield_o,
    output logic configured_o,
    output logic viol_o
);
    typedef struct packed {
        logic shield;
        logic configured;
        logic viol;
    } shd_t;

    shd_t shd_d, shd_q;

    always_comb begin
        shd_d      = shd_q;
        shd_d.viol = dbg_wr_i;
        if (trusted_wr_i) begin
            shd_d.shield     = trusted_shield_i;
            shd_d.configured = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q.shield     <= 1'b1;
            shd_q.configured <= 1'b0;
            shd_q.viol       <= 1'b0;
        end else begin
            shd_q <= shd_d;
        end
    end

    assign shield_o     = shd_q.shield;
    assign configured_o = shd_q.configured;
    assign viol_o       = shd_q.viol;

    // R2: the port stays closed until the trusted agent configures it
    a_r2_closed_until_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        !configured_o |-> shield_o);
    // R3: a debug-side write alone is flagged and changes nothing
    a_r3_dbg_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr_i && !trusted_wr_i) |=> (viol_o && shield_o == $past(shield_o)));
endmodule

// File: rtl/dlg_access_port.sv
module dlg_access_port #(
    parameter int                     ID_W         = 4,
    parameter int                     NUM_ASSETS   = 12,
    parameter int                     DATA_W       = 32,
    parameter logic [2*(2**ID_W)-1:0] ASSET_LEVELS = 32'h00E4E4E4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [1:0]        level_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ID_W-1:0]   req_id_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] asset_rdata_i,
    output logic              asset_en_o,
    output logic              asset_we_o,
    output logic [ID_W-1:0]   asset_id_o,
    output logic [DATA_W-1:0] asset_wdata_o,
    output logic              rsp_valid_o,
    output logic              rsp_grant_o,
    output logic [DATA_W-1:0] rsp_rdata_o
);
    localparam int TAB_N = 2 ** ID_W;

    typedef struct packed {
        logic              valid;
        logic              grant;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    logic [1:0] lvl_tab [TAB_N];
    logic       in_range [TAB_N];

    for (genvar g = 0; g < TAB_N; g++) begin : g_tab
        if (g < NUM_ASSETS) begin : g_used
            assign lvl_tab[g]  = ASSET_LEVELS[2*g +: 2];
            assign in_range[g] = 1'b1;
        end else begin : g_unused
            assign lvl_tab[g]  = 2'd3;
            assign in_range[g] = 1'b0;
        end
    end

    rsp_t rsp_d, rsp_q;
    logic allow;

    always_comb begin
        allow = req_valid_i && enable_i && in_range[req_id_i]
                && (lvl_tab[req_id_i] <= level_i);
        rsp_d.valid = req_valid_i;
        rsp_d.grant = allow;
        rsp_d.rdata = (allow && !req_write_i) ? asset_rdata_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign asset_en_o    = allow;
    assign asset_we_o    = allow && req_write_i;
    assign asset_id_o    = req_id_i;
    assign asset_wdata_o = req_wdata_i;
    assign rsp_valid_o   = rsp_q.valid;
    assign rsp_grant_o   = rsp_q.grant;
    assign rsp_rdata_o   = rsp_q.rdata;

    // R9: denied responses carry zero data
    a_r9_deny_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_grant_o) |-> (rsp_rdata_o == '0));
    // R9: a response follows every request one cycle later
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);
    // R10: the asset strobe is followed by a grant
    a_r10_en_means_grant: assert property (@(posedge clk) disable iff (!rst_n)
        asset_en_o |=> rsp_grant_o);
    // R5: out-of-range identifiers are never granted
    a_r5_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (int'(req_id_i) >= NUM_ASSETS)) |=> !rsp_grant_o);
endmodule

// File: rtl/dbg_level_gate.sv
module dbg_level_gate #(
    parameter int                     ID_W           = 4,
    parameter int                     NUM_ASSETS     = 12,
    parameter int                     DATA_W         = 32,
    parameter int                     LOCKOUT_CYCLES = 1024,
    parameter logic [2*(2**ID_W)-1:0] ASSET_LEVELS   = 32'h00E4E4E4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        boot_stage_i,
    input  logic              auth_valid_i,
    input  logic              auth_pass_i,
    input  logic              trusted_wr_i,
    input  logic              trusted_shield_i,
    input  logic              dbg_shield_wr_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ID_W-1:0]   req_id_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] asset_rdata_i,
    output logic              asset_en_o,
    output logic              asset_we_o,
    output logic [ID_W-1:0]   asset_id_o,
    output logic [DATA_W-1:0] asset_wdata_o,
    output logic              rsp_valid_o,
    output logic              rsp_grant_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic [1:0]        auth_level_o,
    output logic              lockout_o,
    output logic              shield_o,
    output logic              shield_viol_o
);
    logic       configured;
    logic       port_open;
    logic [1:0] level;

    dlg_shield_ctrl i_shield (
        .clk              (clk),
        .rst_n            (rst_n),
        .trusted_wr_i     (trusted_wr_i),
        .trusted_shield_i (trusted_shield_i),
        .dbg_wr_i         (dbg_shield_wr_i),
        .shield_o         (shield_o),
        .configured_o     (configured),
        .viol_o           (shield_viol_o)
    );

    dlg_auth_tracker #(
        .LOCKOUT_CYCLES (LOCKOUT_CYCLES)
    ) i_auth (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_stage_i (boot_stage_i),
        .auth_valid_i (auth_valid_i),
        .auth_pass_i  (auth_pass_i),
        .level_o      (level),
        .lockout_o    (lockout_o)
    );

    assign port_open    = configured && !shield_o;
    assign auth_level_o = level;

    dlg_access_port #(
        .ID_W         (ID_W),
        .NUM_ASSETS   (NUM_ASSETS),
        .DATA_W       (DATA_W),
        .ASSET_LEVELS (ASSET_LEVELS)
    ) i_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (port_open),
        .level_i       (level),
        .req_valid_i   (req_valid_i),
        .req_write_i   (req_write_i),
        .req_id_i      (req_id_i),
        .req_wdata_i   (req_wdata_i),
        .asset_rdata_i (asset_rdata_i),
        .asset_en_o    (asset_en_o),
        .asset_we_o    (asset_we_o),
        .asset_id_o    (asset_id_o),
        .asset_wdata_o (asset_wdata_o),
        .rsp_valid_o   (rsp_valid_o),
        .rsp_grant_o   (rsp_grant_o),
        .rsp_rdata_o   (rsp_rdata_o)
    );

    // R1: a grant needs an open, configured port in the request cycle
    a_r1_no_grant_closed: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant_o |-> $past(!shield_o && configured));
endmodule

// File: tb/test_dbg_level_gate.sv
module test_dbg_level_gate;
    localparam int N_ASSETS = 12;
    localparam int LOCK     = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_stage_i = 2'd0;
    logic        auth_valid_i = 1'b0, auth_pass_i = 1'b0;
    logic        trusted_wr_i = 1'b0, trusted_shield_i = 1'b0, dbg_shield_wr_i = 1'b0;
    logic        req_valid_i = 1'b0, req_write_i = 1'b0;
    logic [3:0]  req_id_i = 4'd0;
    logic [31:0] req_wdata_i = 32'd0;
    logic [31:0] asset_rdata_i;
    logic        asset_en_o, asset_we_o;
    logic [3:0]  asset_id_o;
    logic [31:0] asset_wdata_o;
    logic        rsp_valid_o, rsp_grant_o;
    logic [31:0] rsp_rdata_o;
    logic [1:0]  auth_level_o;
    logic        lockout_o, shield_o, shield_viol_o;

    always #5 clk = ~clk;

    assign asset_rdata_i = 32'hC0DE_0000 | {28'd0, asset_id_o};

    dbg_level_gate i_dbg_level_gate (
        .clk(clk), .rst_n(rst_n), .boot_stage_i(boot_stage_i),
        .auth_valid_i(auth_valid_i), .auth_pass_i(auth_pass_i),
        .trusted_wr_i(trusted_wr_i), .trusted_shield_i(trusted_shield_i),
        .dbg_shield_wr_i(dbg_shield_wr_i), .req_valid_i(req_valid_i),
        .req_write_i(req_write_i), .req_id_i(req_id_i), .req_wdata_i(req_wdata_i),
        .asset_rdata_i(asset_rdata_i), .asset_en_o(asset_en_o), .asset_we_o(asset_we_o),
        .asset_id_o(asset_id_o), .asset_wdata_o(asset_wdata_o),
        .rsp_valid_o(rsp_valid_o), .rsp_grant_o(rsp_grant_o), .rsp_rdata_o(rsp_rdata_o),
        .auth_level_o(auth_level_o), .lockout_o(lockout_o), .shield_o(shield_o),
        .shield_viol_o(shield_viol_o)
    );

    int    checks = 0, fails = 0;
    string phase = "R4";
    bit    finished = 0;

    // behavioural reference state
    int          m_stage, m_auth, m_cnt;
    bit          m_shield, m_cfg, m_viol, m_rv, m_rg;
    logic [31:0] m_rd;

    function automatic bit m_allow(int id);
        return m_shield == 0 && m_cfg && id < N_ASSETS && (id % 4) <= m_auth;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage = 0; m_auth = 1; m_cnt = 0;
            m_shield = 1; m_cfg = 0; m_viol = 0; m_rv = 0; m_rg = 0; m_rd = '0;
        end else begin
            bit g;
            g    = req_valid_i && m_allow(int'(req_id_i));
            m_rv = req_valid_i;
            m_rg = g;
            m_rd = (g && !req_write_i) ? (32'hC0DE_0000 | {28'd0, req_id_i}) : 32'd0;
            if (int'(boot_stage_i) > m_stage) m_stage = int'(boot_stage_i);
            if (auth_valid_i && m_cnt == 0) begin
                if (auth_pass_i) m_auth = (m_stage == 0) ? 3 : 2;
                else begin m_auth = 1; m_cnt = LOCK; end
            end else if (m_cnt > 0) m_cnt--;
            if (m_stage != 0 && m_auth == 3) m_auth = 2;
            m_viol = dbg_shield_wr_i;
            if (trusted_wr_i) begin m_shield = trusted_shield_i; m_cfg = 1; end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R9", "rsp_valid", 32'(rsp_valid_o), 32'(m_rv));
            check({phase, "/R5"}, "rsp_grant", 32'(rsp_grant_o), 32'(m_rg));
            check("R9", "rsp_rdata", rsp_rdata_o, m_rd);
            check({phase, "/R4"}, "auth_level", 32'(auth_level_o), 32'(m_auth));
            check("R8", "lockout", 32'(lockout_o), 32'(m_cnt != 0));
            check({phase, "/R1"}, "shield", 32'(shield_o), 32'(m_shield));
            check("R3", "shield_viol", 32'(shield_viol_o), 32'(m_viol));
        end
    end

    // drive is already applied; check combinational strobes, advance one cycle, clear strobes
    task automatic step();
        bit g;
        #1;
        g = req_valid_i && m_allow(int'(req_id_i));
        check("R10", "asset_en", 32'(asset_en_o), 32'(g));
        check("R10", "asset_we", 32'(asset_we_o), 32'(g && req_write_i));
        @(negedge clk);
        req_valid_i = 0; auth_valid_i = 0; trusted_wr_i = 0; dbg_shield_wr_i = 0;
    endtask

    task automatic sweep();
        for (int w = 0; w < 2; w++) begin
            for (int id = 0; id < 16; id++) begin
                req_valid_i = 1; req_write_i = w[0]; req_id_i = 4'(id);
                req_wdata_i = 32'h1234_0000 + 32'(id);
                step();
            end
        end
        step();
    endtask

    task automatic auth(bit pass);
        auth_valid_i = 1; auth_pass_i = pass; step();
    endtask

    task automatic twrite(bit v);
        trusted_wr_i = 1; trusted_shield_i = v; step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R4: reset state (level 1 public, shield 1 closed, no lockout)
        phase = "R4";
        check("R4", "reset auth_level", 32'(auth_level_o), 32'd1);
        check("R2", "reset shield", 32'(shield_o), 32'd1);
        check("R8", "reset lockout", 32'(lockout_o), 32'd0);
        // R2: unconfigured gate denies everything, even after a full-level pass
        phase = "R2";
        auth(1'b1);
        sweep();
        // R3: debug-side shield write ignored and flagged
        phase = "R3";
        dbg_shield_wr_i = 1; step(); step();
        sweep();
        // R1: configured but closed
        phase = "R1";
        twrite(1'b1);
        sweep();
        // R5: open, full level at stage 0 (from the earlier pass), then public
        phase = "R5";
        twrite(1'b0);
        sweep();
        auth(1'b0);
        phase = "R8";
        sweep();
        // R8: pass strobe on every lockout cycle; the first accepted one ends at the boundary
        for (int i = 0; i < LOCK + 4; i++) begin
            auth_valid_i = 1; auth_pass_i = 1; step();
        end
        phase = "R6";
        sweep();
        // R7: stage advance demotes full; stage cannot go back
        phase = "R7";
        boot_stage_i = 2'd1; step();
        sweep();
        boot_stage_i = 2'd0; step();
        auth(1'b1);
        sweep();
        boot_stage_i = 2'd3; step();
        // R6: pass after boot advanced only gives level 2
        phase = "R6";
        auth(1'b0);
        repeat (LOCK + 2) step();
        auth(1'b1);
        sweep();
        // R3: simultaneous trusted and debug writes, then debug write alone
        phase = "R3";
        trusted_wr_i = 1; trusted_shield_i = 1; dbg_shield_wr_i = 1; step();
        sweep();
        dbg_shield_wr_i = 1; step();
        sweep();
        repeat (2) step();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule